// File: doc/BRIEF.md
# Two-Level Interrupt Priority Arbiter

This block arbitrates among fourteen interrupt request lines. Each line reaches it as an already-latched pending flag. Source 0 is the power-fail source, and it always sits on a fixed top level. Every other source carries a software-set priority bit that places it on a high or a low programmable level. Within one level, the source with the lowest index wins. The block presents the winner to the CPU as a registered request together with an 8-bit vector address and the source index. These outputs hold until the CPU acknowledges them.

On acknowledge, the level of the granted source is pushed onto a small in-service stack. The top of that stack is the level the CPU is servicing now. A new request is raised only when its level is strictly above that level, so nesting is limited to at most three levels. A return-from-interrupt strobe pops one entry. Each source has its own enable. A global enable masks every source except power-fail. Edge detection and flag clearing happen outside the block.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0, `src_o` is 0 and `cur_lvl_o` is 0. The stack is empty.
- R2: When source 0 is pending and its enable is set, source 0 wins over every other source, whatever its priority bit and whatever `glob_en_i` is. Its level code is 3.
- R3: When no power-fail request is eligible, an eligible source whose priority bit is 1 (high, level code 2) wins over any eligible source whose bit is 0 (low, level code 1).
- R4: Among eligible sources on the same level, the one with the lowest index wins.
- R5: The vector for source 0 is 8'h33. For source i in the range 1 to 13, the vector is 8'h03 + 8*(i-1).
- R6: A source i of 1 or more is eligible only when `pend_i[i]`, `en_i[i]` and `glob_en_i` are all 1. Source 0 needs only `pend_i[0]` and `en_i[0]`.
- R7: `hi_pri_i[0]` has no effect on arbitration.
- R8: A request is raised only if the winner's level is strictly greater than `cur_lvl_o`. A request at the same level or a lower level stays pending and raises nothing.
- R9: An `ack_i` sampled while `irq_o` is 1 clears `irq_o` at that edge and pushes the granted level, so `cur_lvl_o` shows that level from then on. An `ack_i` sampled while `irq_o` is 0 is ignored.
- R10: A `reti_i` pops one level, and `cur_lvl_o` returns to the level below it, or to 0. A `reti_i` with an empty stack, or in the same cycle as an accepted acknowledge, is ignored.
- R11: While `irq_o` is 1 and no acknowledge arrives, `irq_o`, `vec_o` and `src_o` hold their values, even if the pending inputs change.
- R12: `irq_o` rises at the first clock edge at which an eligible winner of a sufficient level is present and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 14 | Pending flag per source, bit 0 = power-fail |
| en_i | input | 14 | Enable per source |
| hi_pri_i | input | 14 | Priority bit per source, 1 = high (bit 0 unused) |
| glob_en_i | input | 1 | Global enable for sources 1..13 |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| reti_i | input | 1 | Return from interrupt, pops one level |
| irq_o | output | 1 | Registered interrupt request to the CPU |
| vec_o | output | 8 | Registered vector address of the presented source |
| src_o | output | 4 | Registered index of the presented source |
| cur_lvl_o | output | 2 | Level in service: 0 none, 1 low, 2 high, 3 power-fail |

## Verification
Request, vector and source index are due one clock edge after the inputs that select them are applied. The bench therefore drives inputs on the falling edge and samples on the following falling edge. An acknowledge or a return changes `cur_lvl_o` and drops `irq_o` on the very edge that samples it. A follow-on request caused by the new stack top appears only one edge after that, so each step of the nesting sequence is checked on a separate falling edge. Arbitration is swept over every pair of sources under all four priority-bit combinations, and the winner of each pair is computed arithmetically in the bench.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_PF   = 2'd3
    } lvl_e;

    localparam int unsigned VEC_W     = 8;
    localparam logic [7:0]  PF_VECTOR = 8'h33;
    localparam logic [7:0]  VEC_FIRST = 8'h03;
    localparam int unsigned VEC_STEP  = 8;

    // Vector address of a source: power-fail is fixed, the rest step evenly.
    function automatic logic [VEC_W-1:0] src_vector(input int unsigned idx);
        if (idx == 0) begin
            return PF_VECTOR;
        end
        return VEC_FIRST + VEC_W'(VEC_STEP * (idx - 1));
    endfunction

endpackage

// File: rtl/irq_level_picker.sv
module irq_level_picker #(
    parameter int unsigned N     = 14,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    // Lowest set index wins: scan downward so the last assignment sticks.
    always_comb begin
        hit_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_service_stack.sv
module irq_service_stack
    import irq_arb_pkg::*;
#(
    parameter int unsigned DEPTH = 3,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic [1:0] push_lvl_i,
    input  logic       pop_i,
    output logic [1:0] top_lvl_o
);

    typedef struct packed {
        logic [DEPTH-1:0][1:0] lvl;
        logic [CNT_W-1:0]      cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        int unsigned top_idx;
        stk_d   = stk_q;
        top_idx = (stk_q.cnt == 0) ? 0 : int'(stk_q.cnt) - 1;
        top_lvl_o = (stk_q.cnt == 0) ? LVL_NONE : stk_q.lvl[top_idx];
        if (push_i) begin
            if (int'(stk_q.cnt) < DEPTH) begin
                stk_d.lvl[stk_q.cnt] = push_lvl_i;
                stk_d.cnt            = stk_q.cnt + 1'b1;
            end
        end else if (pop_i && stk_q.cnt != 0) begin
            stk_d.lvl[top_idx] = LVL_NONE;
            stk_d.cnt          = stk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    // Levels only ever nest upward, so a push never meets a full stack.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (int'(stk_q.cnt) < DEPTH));

    // A pushed level must sit above what was in service.
    p_push_above_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (push_lvl_i > top_lvl_o));

    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && stk_q.cnt == 0) |=> (stk_q.cnt == 0));

    p_push_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_lvl_o == $past(push_lvl_i)));

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 14,
    parameter int unsigned NEST_MAX  = 3,
    localparam int unsigned SRC_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] hi_pri_i,
    input  logic               glob_en_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [SRC_W-1:0]   src_o,
    output logic [1:0]         cur_lvl_o
);

    localparam int unsigned NUM_PROG = 2;  // low and high programmable levels
    localparam logic [NUM_SRC-1:0] PF_BIT = NUM_SRC'(1);

    typedef struct packed {
        logic             irq;
        logic [VEC_W-1:0] vec;
        logic [SRC_W-1:0] src;
        logic [1:0]       lvl;
    } out_t;

    out_t out_d, out_q;

    logic                         pf_ok;
    logic [NUM_SRC-1:0]           prog_ok;
    logic [NUM_PROG-1:0][NUM_SRC-1:0] lvl_mask;
    logic [NUM_PROG-1:0]          lvl_hit;
    logic [NUM_PROG-1:0][SRC_W-1:0] lvl_idx;
    logic [1:0]                   cand_lvl;
    logic [SRC_W-1:0]             cand_src;
    logic [1:0]                   top_lvl;
    logic                         accept;
    logic                         pop;

    // Eligibility split per programmable level; power-fail kept apart.
    always_comb begin
        pf_ok       = pend_i[0] & en_i[0];
        prog_ok     = pend_i & en_i & {NUM_SRC{glob_en_i}} & ~PF_BIT;
        lvl_mask[0] = prog_ok & ~hi_pri_i;
        lvl_mask[1] = prog_ok & hi_pri_i;
    end

    for (genvar g = 0; g < NUM_PROG; g++) begin : g_level
        irq_level_picker #(.N(NUM_SRC)) u_pick (
            .req_i (lvl_mask[g]),
            .hit_o (lvl_hit[g]),
            .idx_o (lvl_idx[g])
        );
    end

    always_comb begin
        if (pf_ok) begin
            cand_lvl = LVL_PF;
            cand_src = '0;
        end else if (lvl_hit[1]) begin
            cand_lvl = LVL_HIGH;
            cand_src = lvl_idx[1];
        end else if (lvl_hit[0]) begin
            cand_lvl = LVL_LOW;
            cand_src = lvl_idx[0];
        end else begin
            cand_lvl = LVL_NONE;
            cand_src = '0;
        end
    end

    assign accept = out_q.irq & ack_i;
    assign pop    = reti_i & ~accept;

    irq_service_stack #(.DEPTH(NEST_MAX)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (accept),
        .push_lvl_i (out_q.lvl),
        .pop_i      (pop),
        .top_lvl_o  (top_lvl)
    );

    always_comb begin
        out_d = out_q;
        if (out_q.irq) begin
            if (ack_i) begin
                out_d.irq = 1'b0;
            end
        end else if (cand_lvl > top_lvl) begin
            out_d.irq = 1'b1;
            out_d.vec = src_vector(int'(cand_src));
            out_d.src = cand_src;
            out_d.lvl = cand_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o     = out_q.irq;
    assign vec_o     = out_q.vec;
    assign src_o     = out_q.src;
    assign cur_lvl_o = top_lvl;

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.irq && !ack_i) |=> (out_q.irq && $stable(out_q.vec) && $stable(out_q.src)));

    p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.irq && ack_i) |=> !out_q.irq);

    p_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.irq |-> (out_q.lvl > top_lvl));

    p_pf_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.irq && out_q.src == '0) |-> (out_q.vec == PF_VECTOR && out_q.lvl == LVL_PF));

    p_pf_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_q.irq && pf_ok && top_lvl != LVL_PF) |=> (out_q.irq && out_q.src == '0));

endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;

    localparam int N = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend = '0;
    logic [N-1:0]  en = '0;
    logic [N-1:0]  hi = '0;
    logic          ge = 1'b0;
    logic          ack = 1'b0;
    logic          reti = 1'b0;
    logic          irq;
    logic [7:0]    vec;
    logic [3:0]    src;
    logic [1:0]    cur;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    irq_prio_arbiter u_irq_prio_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .en_i      (en),
        .hi_pri_i  (hi),
        .glob_en_i (ge),
        .ack_i     (ack),
        .reti_i    (reti),
        .irq_o     (irq),
        .vec_o     (vec),
        .src_o     (src),
        .cur_lvl_o (cur)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int exp_vec(input int s);
        return (s == 0) ? 'h33 : 'h03 + 8 * (s - 1);
    endfunction

    // Winner index or -1, computed from the requirement text.
    function automatic int exp_win(input logic [N-1:0] p, input logic [N-1:0] e,
                                   input logic [N-1:0] h, input logic g, input int cl,
                                   output int lvl);
        int best = -1;
        lvl = 0;
        if (p[0] && e[0]) begin
            best = 0;
            lvl = 3;
        end else begin
            for (int i = 1; i < N; i++) begin
                int l;
                if (!(p[i] && e[i] && g)) continue;
                l = h[i] ? 2 : 1;
                if (l > lvl) begin
                    lvl = l;
                    best = i;
                end
            end
        end
        if (best >= 0 && lvl <= cl) best = -1;
        return best;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pair_case(input int a, input int b, input int pat);
        int w;
        int lv;
        pend = '0;
        hi = '0;
        pend[a] = 1'b1;
        pend[b] = 1'b1;
        hi[a] = pat[0];
        hi[b] = pat[1];
        w = exp_win(pend, en, hi, ge, 0, lv);
        step();
        chk("R12 irq rises", int'(irq), 1);
        chk("R3/R4 winner", int'(src), w);
        chk("R5 vector", int'(vec), exp_vec(w));
        ack = 1'b1;
        step();
        ack = 1'b0;
        chk("R9 level pushed", int'(cur), lv);
        chk("R9 irq dropped", int'(irq), 0);
        pend = '0;
        reti = 1'b1;
        step();
        reti = 1'b0;
        chk("R10 popped", int'(cur), 0);
        step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int lv;
        repeat (3) step();
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 vec reset", int'(vec), 0);
        chk("R1 src reset", int'(src), 0);
        chk("R1 level reset", int'(cur), 0);
        rst_n = 1'b1;
        en = '1;
        ge = 1'b1;
        step();

        // R2 R3 R4 R5 R7: every pair under every priority pattern.
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                for (int pat = 0; pat < 4; pat++) begin
                    pair_case(a, b, pat);
                end
            end
        end

        // R2: power-fail passes the global mask.
        ge = 1'b0;
        pend = '0;
        pend[0] = 1'b1;
        pend[4] = 1'b1;
        hi[4] = 1'b1;
        step();
        chk("R2 pf with global off", int'(irq), 1);
        chk("R2 pf src", int'(src), 0);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R2 pf level", int'(cur), 3);
        pend = '0; reti = 1'b1; step(); reti = 1'b0; step();

        // R6: global enable off masks ordinary sources.
        pend[5] = 1'b1;
        step(); step();
        chk("R6 global mask", int'(irq), 0);
        // R9: ack with no request is ignored.
        ack = 1'b1; step(); ack = 1'b0;
        chk("R9 stray ack", int'(cur), 0);
        ge = 1'b1;
        // R6: per-source enable.
        pend = '0; hi = '0;
        pend[3] = 1'b1; pend[7] = 1'b1; en[3] = 1'b0;
        step();
        chk("R6 per-source mask", int'(src), 7);
        ack = 1'b1; step(); ack = 1'b0;
        pend = '0; reti = 1'b1; step(); reti = 1'b0; step();
        en = '1;
        // R6: power-fail own enable.
        pend[0] = 1'b1; en[0] = 1'b0;
        step(); step();
        chk("R6 pf enable", int'(irq), 0);
        pend = '0; en = '1; step();

        // R11 R8 R10: nesting sequence.
        pend[9] = 1'b1;
        step();
        chk("R12 low request", int'(vec), 'h43);
        pend[1] = 1'b1; hi[1] = 1'b1;
        step(); step();
        chk("R11 vec held", int'(vec), 'h43);
        chk("R11 src held", int'(src), 9);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R9 low in service", int'(cur), 1);
        step();
        chk("R8 high preempts low", int'(vec), 'h03);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R9 high in service", int'(cur), 2);
        pend[2] = 1'b1; hi[2] = 1'b1;
        step(); step();
        chk("R8 same level blocked", int'(irq), 0);
        pend[0] = 1'b1;
        step();
        chk("R8 pf preempts high", int'(vec), 'h33);
        ack = 1'b1; reti = 1'b1; step(); ack = 1'b0; reti = 1'b0;
        chk("R10 reti with ack ignored", int'(cur), 3);
        pend = '0;
        reti = 1'b1; step();
        chk("R10 pop to high", int'(cur), 2);
        step();
        chk("R10 pop to low", int'(cur), 1);
        step();
        chk("R10 pop to none", int'(cur), 0);
        step(); reti = 1'b0;
        chk("R10 empty pop ignored", int'(cur), 0);
        chk("R10 no irq after pops", int'(irq), 0);
        void'(exp_win(pend, en, hi, ge, 0, lv));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule